// File: doc/BRIEF.md
# Ring Stop with Local Packet Insertion

This block is one stop on a one-way ring that links several cores. Every link carries one flit per cycle under a valid/blocked handshake: a flit moves on a clock edge only when its valid is high and the blocked signal from the receiving side is low. Traffic for other stops flows straight from the ring input to the ring output. Packets addressed to this stop are sorted into one receive FIFO per virtual channel, and the core drains each FIFO through its own valid/blocked port.

The core sends data through an inject port. It gives the destination, the virtual channel and the payload flits, and it marks the final one. The stop writes the header flit itself and stamps every flit of the packet with a per-packet sequence tag. The packet then goes out as one unbroken run from header to tail. While that run is on the ring output, the stop blocks ring traffic arriving upstream.

A five-state controller makes the routing decisions. ST_IDLE means no packet is open. ST_PASS forwards a foreign packet. ST_EJECT writes a packet into the receive FIFO of the channel its header named. ST_INJ_HEAD presents the locally built header. ST_INJ_BODY forwards the core's flits. The transitions are as follows:
- ST_IDLE goes to ST_PASS or ST_EJECT when a ring header is accepted.
- ST_IDLE goes to ST_INJ_HEAD when the core requests and the ring input is idle.
- ST_INJ_HEAD goes to ST_INJ_BODY when the header is accepted.
- ST_PASS, ST_EJECT and ST_INJ_BODY return to ST_IDLE when their tail flit is accepted.

Top module: `ring_stop`

## Requirements
- R1: After synchronous reset, the ring output valid and all receive valids are low, the ring input is not blocked, and the inject port is blocked.
- R2: A header whose destination field differs from NODE_ID appears unchanged on the ring output in the same cycle. The body and tail flits that follow it do the same, until the tail is accepted.
- R3: A header whose destination field equals NODE_ID is not driven on the ring output. It and its following flits up to the tail enter the receive FIFO selected by the header's channel field, and leave that FIFO in arrival order. A receive flit held by its blocked input stays unchanged.
- R4: The flit layout is as follows. Bits [FW-1:FW-2] carry the kind: 01 header, 10 body, 11 tail. The next UID_W bits carry the tag. The low DATA_W bits carry the data. In a header, data bits [NW-1:0] hold the destination, bits [2NW-1:NW] the source, and bits [2NW+VW-1:2NW] the channel. The remaining data bits are zero.
- R5: An injected packet starts with a header flit carrying the requested channel, NODE_ID as source and the requested destination. After it, each core flit is forwarded with its data unchanged: as a tail flit if marked last, otherwise as a body flit. The header takes one cycle after the request is first seen in ST_IDLE.
- R6: From the cycle the local header is presented until the local tail is accepted, the ring input is blocked. A ring flit waiting there is forwarded once the tail has gone.
- R7: While a foreign packet is open (header accepted, tail not yet accepted), the inject port stays blocked and no local header is driven.
- R8: When the receive FIFO of the open packet's channel is full, the ring input is blocked. No flit is lost, and the waiting flit is accepted after the core frees a slot.
- R9: When the ring output is blocked, the flit shown there stays unchanged and valid until it is accepted.
- R10: All flits of one injected packet carry the same tag. The first packet after reset carries tag 0, and each later packet carries the previous tag plus one, modulo 2^UID_W.
- R11: A body or tail flit that arrives in ST_IDLE is accepted and discarded. It causes no ring output, no receive entry and no change of state.
- R12: When a ring header and an inject request are both valid in ST_IDLE, the ring header is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rin_valid | input | 1 | Ring input flit valid |
| rin_flit | input | FW | Ring input flit |
| rin_blocked | output | 1 | Ring input cannot accept this cycle |
| rout_valid | output | 1 | Ring output flit valid |
| rout_flit | output | FW | Ring output flit |
| rout_blocked | input | 1 | Downstream stop cannot accept |
| inj_valid | input | 1 | Core offers a payload flit |
| inj_last | input | 1 | Offered flit closes the packet |
| inj_data | input | DATA_W | Payload of the offered flit |
| inj_dest | input | NW | Destination stop of the packet |
| inj_vc | input | VW | Virtual channel of the packet |
| inj_blocked | output | 1 | Offered flit not taken this cycle |
| ej_valid | output | VCS | Per-channel receive flit valid |
| ej_flit | output | VCS*FW | Per-channel receive flit, channel v at bits [v*FW +: FW] |
| ej_blocked | input | VCS | Per-channel core cannot take the receive flit |

## Verification
The hardest situation to reach from the ports is a collision: ring traffic arrives while the stop is inside its own injection, and a receive FIFO fills while a packet is only half delivered. The bench causes the first by raising a foreign header in the cycle the local header is presented. It keeps that header waiting through the body and tail, and then checks that the header is forwarded unchanged. For the second, it holds the core's receive blocked until the FIFO is full, leaves the tail waiting at the ring input, and frees exactly one slot. It then checks that the tail is taken on the following edge and that the drained order is intact.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

    // Flit kind codes, held in the top two bits of every flit.
    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_HEAD = 2'b01,
        KIND_BODY = 2'b10,
        KIND_TAIL = 2'b11
    } flit_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_EJECT,
        ST_INJ_HEAD,
        ST_INJ_BODY
    } stop_state_e;

endpackage

// File: rtl/ring_stop_fifo.sv
module ring_stop_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    output logic [W-1:0] dout,
    input  logic         out_blocked
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full      = (cnt_q == (AW+1)'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign dout      = mem[rd_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && !out_blocked;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ring_stop_hdr.sv
module ring_stop_hdr
    import ring_stop_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int UID_W   = 6,
    parameter int NW      = 2,
    parameter int VW      = 1,
    parameter int NODE_ID = 0
) (
    input  logic [VW-1:0]            vc,
    input  logic [NW-1:0]            dest,
    input  logic [UID_W-1:0]         uid,
    output logic [DATA_W+UID_W+1:0]  flit
);
    localparam logic [NW-1:0] SRC = NW'(NODE_ID);
    logic [DATA_W-1:0] data;

    // Header packing: channel above source above destination.
    always_comb begin
        data = '0;
        data[2*NW+VW-1:0] = {vc, SRC, dest};
        flit = {KIND_HEAD, uid, data};
    end
endmodule

// File: rtl/ring_stop.sv
module ring_stop
    import ring_stop_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int VCS        = 2,
    parameter int DATA_W     = 16,
    parameter int UID_W      = 6,
    parameter int FIFO_DEPTH = 4,
    parameter int NODE_ID    = 1,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int VW = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int FW = DATA_W + UID_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rin_valid,
    input  logic [FW-1:0]     rin_flit,
    output logic              rin_blocked,
    output logic              rout_valid,
    output logic [FW-1:0]     rout_flit,
    input  logic              rout_blocked,
    input  logic              inj_valid,
    input  logic              inj_last,
    input  logic [DATA_W-1:0] inj_data,
    input  logic [NW-1:0]     inj_dest,
    input  logic [VW-1:0]     inj_vc,
    output logic              inj_blocked,
    output logic [VCS-1:0]    ej_valid,
    output logic [VCS*FW-1:0] ej_flit,
    input  logic [VCS-1:0]    ej_blocked
);
    localparam logic [NW-1:0] SELF = NW'(NODE_ID);

    stop_state_e       state_q, state_d;
    logic [VW-1:0]     vc_q, ivc_q;
    logic [NW-1:0]     dest_q;
    logic [UID_W-1:0]  uid_q;
    logic [VCS-1:0]    full, push;
    logic [FW-1:0]     hdr_flit;

    flit_kind_e        rin_kind;
    logic [NW-1:0]     rin_dest;
    logic [VW-1:0]     rin_vc;
    logic              rin_fire, inj_fire;

    assign rin_kind = flit_kind_e'(rin_flit[FW-1 -: 2]);
    assign rin_dest = rin_flit[NW-1:0];
    assign rin_vc   = rin_flit[2*NW+VW-1:2*NW];
    assign rin_fire = rin_valid && !rin_blocked;
    assign inj_fire = inj_valid && !inj_blocked;

    ring_stop_hdr #(
        .DATA_W(DATA_W), .UID_W(UID_W), .NW(NW), .VW(VW), .NODE_ID(NODE_ID)
    ) u_hdr (
        .vc(ivc_q), .dest(dest_q), .uid(uid_q), .flit(hdr_flit)
    );

    for (genvar v = 0; v < VCS; v++) begin : g_vc
        ring_stop_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst(rst),
            .push(push[v]), .din(rin_flit), .full(full[v]),
            .out_valid(ej_valid[v]), .dout(ej_flit[v*FW +: FW]),
            .out_blocked(ej_blocked[v])
        );
    end

    // State register and packet-scoped latches.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vc_q    <= '0;
            ivc_q   <= '0;
            dest_q  <= '0;
            uid_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_EJECT) vc_q <= rin_vc;
            if (state_q == ST_IDLE && state_d == ST_INJ_HEAD) begin
                dest_q <= inj_dest;
                ivc_q  <= inj_vc;
            end
            if (state_q == ST_INJ_BODY && state_d == ST_IDLE) uid_q <= uid_q + 1'b1;
        end
    end

    // Next state and handshake outputs.
    always_comb begin
        state_d     = state_q;
        rout_valid  = 1'b0;
        rout_flit   = '0;
        rin_blocked = 1'b1;
        inj_blocked = 1'b1;
        push        = '0;
        unique case (state_q)
            ST_IDLE: begin
                rin_blocked = 1'b0;
                if (rin_valid && rin_kind == KIND_HEAD) begin
                    if (rin_dest == SELF) begin
                        rin_blocked  = full[rin_vc];
                        push[rin_vc] = !full[rin_vc];
                        if (!full[rin_vc]) state_d = ST_EJECT;
                    end else begin
                        rout_valid  = 1'b1;
                        rout_flit   = rin_flit;
                        rin_blocked = rout_blocked;
                        if (!rout_blocked) state_d = ST_PASS;
                    end
                end else if (!rin_valid && inj_valid) begin
                    state_d = ST_INJ_HEAD;
                end
            end
            ST_PASS: begin
                rout_valid  = rin_valid;
                rout_flit   = rin_flit;
                rin_blocked = rout_blocked;
                if (rin_fire && rin_kind == KIND_TAIL) state_d = ST_IDLE;
            end
            ST_EJECT: begin
                rin_blocked  = full[vc_q];
                push[vc_q]   = rin_valid && !full[vc_q];
                if (rin_fire && rin_kind == KIND_TAIL) state_d = ST_IDLE;
            end
            ST_INJ_HEAD: begin
                rout_valid = 1'b1;
                rout_flit  = hdr_flit;
                if (!rout_blocked) state_d = ST_INJ_BODY;
            end
            ST_INJ_BODY: begin
                rout_valid  = inj_valid;
                rout_flit   = {(inj_last ? KIND_TAIL : KIND_BODY), uid_q, inj_data};
                inj_blocked = rout_blocked;
                if (inj_fire && inj_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
    parameter int FW     = 24,
    parameter int VCS    = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rin_valid,
    input logic [FW-1:0]     rin_flit,
    input logic              rin_blocked,
    input logic              rout_valid,
    input logic [FW-1:0]     rout_flit,
    input logic              rout_blocked,
    input logic              inj_valid,
    input logic              inj_last,
    input logic [DATA_W-1:0] inj_data,
    input logic              inj_blocked,
    input logic [VCS-1:0]    ej_valid,
    input logic [VCS*FW-1:0] ej_flit,
    input logic [VCS-1:0]    ej_blocked
);
    logic inj_open, ring_open;
    logic [1:0] rin_k, rout_k;
    assign rin_k  = rin_flit[FW-1 -: 2];
    assign rout_k = rout_flit[FW-1 -: 2];

    // Port-level trackers of open packets.
    always_ff @(posedge clk) begin
        if (rst) begin
            inj_open  <= 1'b0;
            ring_open <= 1'b0;
        end else begin
            if (rout_valid && !rout_blocked && rout_k == 2'b01 && rin_blocked) inj_open <= 1'b1;
            else if (inj_valid && !inj_blocked && inj_last) inj_open <= 1'b0;
            if (rin_valid && !rin_blocked && rin_k == 2'b01) ring_open <= 1'b1;
            else if (rin_valid && !rin_blocked && rin_k == 2'b11) ring_open <= 1'b0;
        end
    end

    assert_pass_exact_R2: assert property (@(posedge clk) disable iff (rst)
        (rin_valid && !rin_blocked && rout_valid) |-> rout_flit == rin_flit);

    for (genvar v = 0; v < VCS; v++) begin : g_ej
        assert_eject_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (ej_valid[v] && ej_blocked[v]) |=> (ej_valid[v] && $stable(ej_flit[v*FW +: FW])));
    end

    assert_kind_legal_R4: assert property (@(posedge clk) disable iff (rst)
        rout_valid |-> rout_k != 2'b00);

    assert_inject_forward_R5: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_blocked) |-> (rout_valid && rout_flit[DATA_W-1:0] == inj_data
                                         && rout_k == (inj_last ? 2'b11 : 2'b10)));

    assert_ring_held_R6: assert property (@(posedge clk) disable iff (rst)
        inj_open |-> rin_blocked);

    assert_inject_waits_R7: assert property (@(posedge clk) disable iff (rst)
        ring_open |-> inj_blocked);

    assert_out_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (rout_valid && rout_blocked) |=> (rout_valid && $stable(rout_flit)));
endmodule

bind ring_stop ring_stop_chk #(.FW(FW), .VCS(VCS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .rin_valid(rin_valid), .rin_flit(rin_flit), .rin_blocked(rin_blocked),
    .rout_valid(rout_valid), .rout_flit(rout_flit), .rout_blocked(rout_blocked),
    .inj_valid(inj_valid), .inj_last(inj_last), .inj_data(inj_data),
    .inj_blocked(inj_blocked),
    .ej_valid(ej_valid), .ej_flit(ej_flit), .ej_blocked(ej_blocked)
);

// File: tb/ring_stop_test.sv
module ring_stop_test;
    localparam int NODES = 4, VCS = 2, DATA_W = 16, UID_W = 6, DEPTH = 4, NODE_ID = 1;
    localparam int NW = 2, VW = 1, FW = DATA_W + UID_W + 2;
    localparam logic [1:0] K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

    logic clk = 1'b0, rst = 1'b1;
    logic rin_valid = 1'b0, rout_blocked = 1'b0;
    logic [FW-1:0] rin_flit = '0;
    logic inj_valid = 1'b0, inj_last = 1'b0;
    logic [DATA_W-1:0] inj_data = '0;
    logic [NW-1:0] inj_dest = '0;
    logic [VW-1:0] inj_vc = '0;
    logic [VCS-1:0] ej_blocked = '1;
    logic rin_blocked, rout_valid, inj_blocked;
    logic [FW-1:0] rout_flit;
    logic [VCS-1:0] ej_valid;
    logic [VCS*FW-1:0] ej_flit;

    int checks = 0, failures = 0;
    logic [UID_W-1:0] exp_uid = '0;

    always #4 clk = ~clk;

    ring_stop #(.NODES(NODES), .VCS(VCS), .DATA_W(DATA_W), .UID_W(UID_W),
                .FIFO_DEPTH(DEPTH), .NODE_ID(NODE_ID)) uut (
        .clk(clk), .rst(rst),
        .rin_valid(rin_valid), .rin_flit(rin_flit), .rin_blocked(rin_blocked),
        .rout_valid(rout_valid), .rout_flit(rout_flit), .rout_blocked(rout_blocked),
        .inj_valid(inj_valid), .inj_last(inj_last), .inj_data(inj_data),
        .inj_dest(inj_dest), .inj_vc(inj_vc), .inj_blocked(inj_blocked),
        .ej_valid(ej_valid), .ej_flit(ej_flit), .ej_blocked(ej_blocked)
    );

    function automatic logic [FW-1:0] mkflit(input logic [1:0] k, input logic [UID_W-1:0] u,
                                            input logic [DATA_W-1:0] d);
        return {k, u, d};
    endfunction

    function automatic logic [DATA_W-1:0] mkhdr(input int vc, input int src, input int dest);
        return DATA_W'(dest) | (DATA_W'(src) << NW) | (DATA_W'(vc) << (2*NW));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk(!rout_valid && ej_valid == '0, "R1 outputs quiet after reset",
            FW'({rout_valid, ej_valid}), '0);
        chk(!rin_blocked && inj_blocked, "R1 handshakes after reset",
            FW'({rin_blocked, inj_blocked}), FW'(2'b01));
    endtask

    task automatic t_pass();
        logic [FW-1:0] f [3];
        f[0] = mkflit(K_HEAD, 6'h11, mkhdr(0, 3, 2));
        f[1] = mkflit(K_BODY, 6'h11, 16'h1234);
        f[2] = mkflit(K_TAIL, 6'h11, 16'hBEEF);
        for (int i = 0; i < 3; i++) begin
            rin_valid = 1'b1; rin_flit = f[i]; #1;
            chk(rout_valid && rout_flit == f[i] && !rin_blocked, "R2 flit passes unchanged",
                rout_flit, f[i]);
            chk(ej_valid == '0, "R2 nothing received", FW'(ej_valid), '0);
            tick();
        end
        rin_valid = 1'b0; rin_flit = '0;
    endtask

    task automatic t_eject();
        logic [FW-1:0] f [3];
        f[0] = mkflit(K_HEAD, 6'h22, mkhdr(1, 0, NODE_ID));
        f[1] = mkflit(K_BODY, 6'h22, 16'hAAAA);
        f[2] = mkflit(K_TAIL, 6'h22, 16'h5555);
        ej_blocked = 2'b11;
        for (int i = 0; i < 3; i++) begin
            rin_valid = 1'b1; rin_flit = f[i]; #1;
            chk(!rin_blocked && !rout_valid, "R3 own packet taken off ring",
                FW'({rin_blocked, rout_valid}), '0);
            tick();
        end
        rin_valid = 1'b0; #1;
        chk(ej_valid == 2'b10, "R3 packet lands in channel 1", FW'(ej_valid), FW'(2'b10));
        ej_blocked = 2'b01;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(ej_flit[FW +: FW] == f[i], "R3 receive order", ej_flit[FW +: FW], f[i]);
            if (i == 0)
                chk(ej_flit[FW + 4] == 1'b1 && ej_flit[FW +: 2] == 2'(NODE_ID),
                    "R4 header channel and destination bits", ej_flit[FW +: FW], f[0]);
            tick();
        end
        ej_blocked = 2'b11; #1;
        chk(ej_valid == '0, "R3 channel drained", FW'(ej_valid), '0);
    endtask

    task automatic t_full();
        logic [FW-1:0] f [5];
        f[0] = mkflit(K_HEAD, 6'h05, mkhdr(0, 2, NODE_ID));
        for (int i = 1; i < 4; i++) f[i] = mkflit(K_BODY, 6'h05, DATA_W'(16'h0100 + i));
        f[4] = mkflit(K_TAIL, 6'h05, 16'h0F0F);
        ej_blocked = 2'b11;
        for (int i = 0; i < 4; i++) begin
            rin_valid = 1'b1; rin_flit = f[i]; tick();
        end
        rin_flit = f[4]; #1;
        chk(rin_blocked, "R8 full channel blocks ring", FW'(rin_blocked), FW'(1));
        tick();
        ej_blocked = 2'b10; #1;
        chk(rin_blocked && ej_flit[FW-1:0] == f[0], "R8 still blocked before pop",
            ej_flit[FW-1:0], f[0]);
        tick();
        ej_blocked = 2'b11; #1;
        chk(!rin_blocked, "R8 freed slot accepts waiting tail", FW'(rin_blocked), '0);
        tick();
        rin_valid = 1'b0; ej_blocked = 2'b10;
        for (int i = 1; i < 5; i++) begin
            #1;
            chk(ej_flit[FW-1:0] == f[i], "R8 no flit lost", ej_flit[FW-1:0], f[i]);
            tick();
        end
        ej_blocked = 2'b00; #1;
        chk(ej_valid == '0, "R8 channel empty", FW'(ej_valid), '0);
    endtask

    task automatic t_inject_vs_ring();
        logic [FW-1:0] rh, rt, e;
        rh = mkflit(K_HEAD, 6'h3F, mkhdr(0, 3, 2));
        rt = mkflit(K_TAIL, 6'h3F, 16'h7777);
        inj_valid = 1'b1; inj_last = 1'b0; inj_data = 16'hC0DE; inj_dest = 2'd3; inj_vc = 1'b1; #1;
        chk(inj_blocked && !rout_valid, "R5 header follows request by one cycle",
            FW'({inj_blocked, rout_valid}), FW'(2'b10));
        tick();
        rin_valid = 1'b1; rin_flit = rh; #1;
        e = mkflit(K_HEAD, exp_uid, mkhdr(1, NODE_ID, 3));
        chk(rout_valid && rout_flit == e, "R5 built header", rout_flit, e);
        chk(rin_blocked, "R6 ring held during local header", FW'(rin_blocked), FW'(1));
        tick();
        #1;
        e = mkflit(K_BODY, exp_uid, 16'hC0DE);
        chk(rout_flit == e && !inj_blocked && rin_blocked, "R5 R6 body forwarded, ring held",
            rout_flit, e);
        tick();
        inj_last = 1'b1; inj_data = 16'hF00D; #1;
        e = mkflit(K_TAIL, exp_uid, 16'hF00D);
        chk(rout_flit == e && rin_blocked, "R10 tail with same tag, ring held", rout_flit, e);
        tick();
        inj_valid = 1'b0; inj_last = 1'b0; exp_uid++; #1;
        chk(rout_valid && rout_flit == rh, "R6 waiting ring header resumes", rout_flit, rh);
        tick();
        rin_flit = rt; #1;
        chk(rout_flit == rt, "R2 ring tail after resume", rout_flit, rt);
        tick();
        rin_valid = 1'b0;
    endtask

    task automatic t_stall();
        logic [FW-1:0] e;
        inj_valid = 1'b1; inj_last = 1'b1; inj_data = 16'h0042; inj_dest = 2'd0; inj_vc = 1'b0;
        rout_blocked = 1'b1;
        tick();
        e = mkflit(K_HEAD, exp_uid, mkhdr(0, NODE_ID, 0));
        for (int i = 0; i < 2; i++) begin
            #1;
            chk(rout_valid && rout_flit == e, "R9 header held while blocked", rout_flit, e);
            tick();
        end
        rout_blocked = 1'b0; #1;
        chk(rout_flit == e, "R10 second packet tag", rout_flit, e);
        tick();
        #1;
        e = mkflit(K_TAIL, exp_uid, 16'h0042);
        chk(rout_flit == e && !inj_blocked, "R5 single payload as tail", rout_flit, e);
        tick();
        inj_valid = 1'b0; inj_last = 1'b0; exp_uid++;
    endtask

    task automatic t_priority();
        logic [FW-1:0] f [3];
        logic [FW-1:0] e;
        f[0] = mkflit(K_HEAD, 6'h05, mkhdr(0, 3, 2));
        f[1] = mkflit(K_BODY, 6'h05, 16'h1111);
        f[2] = mkflit(K_TAIL, 6'h05, 16'h2222);
        inj_valid = 1'b1; inj_last = 1'b1; inj_data = 16'h0077; inj_dest = 2'd2; inj_vc = 1'b0;
        for (int i = 0; i < 3; i++) begin
            rin_valid = 1'b1; rin_flit = f[i]; #1;
            chk(rout_flit == f[i] && inj_blocked,
                (i == 0) ? "R12 ring header wins" : "R7 inject waits for ring tail",
                rout_flit, f[i]);
            tick();
        end
        rin_valid = 1'b0; #1;
        chk(!rout_valid && inj_blocked, "R7 idle cycle before local header",
            FW'({rout_valid, inj_blocked}), FW'(2'b01));
        tick();
        #1;
        e = mkflit(K_HEAD, exp_uid, mkhdr(0, NODE_ID, 2));
        chk(rout_flit == e, "R10 third packet tag", rout_flit, e);
        tick();
        #1;
        e = mkflit(K_TAIL, exp_uid, 16'h0077);
        chk(rout_flit == e, "R5 tail after wait", rout_flit, e);
        tick();
        inj_valid = 1'b0; inj_last = 1'b0; exp_uid++;
    endtask

    task automatic t_stray();
        logic [FW-1:0] h, t;
        ej_blocked = 2'b00;
        h = mkflit(K_HEAD, 6'h09, mkhdr(1, 0, 3));
        t = mkflit(K_TAIL, 6'h09, 16'h9999);
        rin_valid = 1'b1; rin_flit = mkflit(K_BODY, 6'h08, 16'hDEAD); #1;
        chk(!rin_blocked && !rout_valid, "R11 stray body dropped",
            FW'({rin_blocked, rout_valid}), '0);
        tick();
        rin_flit = mkflit(K_TAIL, 6'h08, 16'hDEAD); #1;
        chk(!rin_blocked && !rout_valid, "R11 stray tail dropped",
            FW'({rin_blocked, rout_valid}), '0);
        tick();
        rin_valid = 1'b0; #1;
        chk(ej_valid == '0 && !rout_valid, "R11 nothing stored", FW'(ej_valid), '0);
        rin_valid = 1'b1; rin_flit = h; #1;
        chk(rout_valid && rout_flit == h, "R11 state unchanged after strays", rout_flit, h);
        tick();
        rin_flit = t; tick();
        rin_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        t_pass();
        t_eject();
        t_full();
        t_inject_vs_ring();
        t_stall();
        t_priority();
        t_stray();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule